// File: doc/BRIEF.md
# Framed Synchronous Serial Receiver

This block receives a serial bit stream on its own clock, which is the externally supplied receive clock. The block is either enabled or disabled. When enabled, it waits for a start event. The start event is either a continuous start or a chosen edge of a frame-sync input. A programmable delay follows the start event. After the delay, an optional synchronization field is captured, and then a programmable number of data words is captured. When the frame is complete, the receiver returns to waiting for the next start event.

Each data word has a programmable length and a programmable bit order. Every finished word lands right-aligned in a holding register, and the upper bits are zero. A finished word raises a ready flag. If a word finishes while the previous word is still unread, an overrun flag is raised and the new word replaces the old one anyway. The sync field is stored in a separate register and never touches the ready flag.

Software reads the holding register, the status word and the sync register through a small read port with a read strobe.

Top module: `fsr_receiver`

## Requirements
- R1: While disabled, the receiver samples nothing and ignores start events. A `dis_cmd` pulse disables it at the next edge and wins over a simultaneous `en_cmd`. An `en_cmd` pulse while disabled moves it into the waiting state. The ready and overrun flags keep their values across a disable.
- R2: A frame begins only on a start event seen while waiting. The selector `cfg_start_sel` has four codes: 0 is a continuous start (every waiting cycle), 1 is a rising edge of `rx_fs`, 2 is a falling edge, and 3 is either edge. An edge is taken against the value of `rx_fs` on the previous clock. `rx_fs` is tracked even while the receiver is disabled.
- R3: With `cfg_delay` = D, the first bit is sampled at the edge D+1 cycles after the edge on which the start event was seen. With D = 0 it is sampled on the next edge.
- R4: On the edge that samples the last bit of a data word, the whole word, including that bit, is written to the holding register and `rx_rdy` is set.
- R5: If a data word completes while `rx_rdy` is set, and the holding register is not being read in that same cycle, `rx_ovr` is set. The holding register is still overwritten.
- R6: The data length is `cfg_data_len`+1 bits, from 1 to 32. Words are right-aligned and zero-extended.
- R7: With `cfg_msb_first`=1, the first bit received ends up in bit position length-1. With `cfg_msb_first`=0, it ends up in bit 0. The same order applies to the sync field.
- R8: A frame carries `cfg_words`+1 data words, from 1 to 16. After the last one, the receiver waits for a new start event.
- R9: When `cfg_sync_len` is nonzero, that many bits (1 to 16) are captured right after the delay. They go into the sync register, read at address 2, and do not change `rx_rdy`. When `cfg_sync_len` is 0, data starts at once.
- R10: Reading uses `rd_addr` with `rd_en`, and `rd_data` is combinational. Address 0 returns the holding register and clears `rx_rdy` at the edge. Address 1 returns status, with bit 2 = overrun, bit 1 = ready, bit 0 = enabled, and clears `rx_ovr` at the edge. Address 2 returns the sync register, and address 3 returns zero. A word completing in the same cycle wins over these clears. All registers and flags are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_cmd | input | 1 | Enable command pulse |
| dis_cmd | input | 1 | Disable command pulse |
| rx_data | input | 1 | Serial data in |
| rx_fs | input | 1 | Frame-sync input |
| cfg_start_sel | input | 2 | Start event select |
| cfg_delay | input | 8 | Start delay in cycles |
| cfg_sync_len | input | 5 | Sync field bits, 0 = none |
| cfg_data_len | input | 5 | Data word length minus one |
| cfg_msb_first | input | 1 | Bit order select |
| cfg_words | input | 4 | Words per frame minus one |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data |
| rx_rdy | output | 1 | Ready flag |
| rx_ovr | output | 1 | Overrun flag |

## Verification
Pseudo-random serial data is applied under five configurations:
- a rising-edge start with a nonzero delay, 8-bit words and MSB first, which tests delay counting and word assembly;
- a falling-edge start with 32-bit words and LSB first, which tests bit placement at full width;
- a continuous start with 1-bit words and no reads, which forces repeated overrun;
- an any-edge start with a 5-bit sync field and three 12-bit words, which separates the sync register from the data path;
- a disable in the middle of a frame while `rx_fs` keeps toggling, which shows that start events are ignored.

The read strobe hits random addresses at varying rates, so read-clear and complete-wins races occur, and a mismatch in either flag shows up on the very cycle it happens.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT,
    ST_DELAY,
    ST_SYNC,
    ST_DATA
  } fsr_state_e;

  typedef enum logic [1:0] {
    START_CONT = 2'd0,
    START_RISE = 2'd1,
    START_FALL = 2'd2,
    START_ANY  = 2'd3
  } fsr_start_e;

  localparam logic [1:0] ADDR_HOLD = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_SYNC = 2'd2;

  // Start event decision from the current and previous frame-sync level
  function automatic logic start_hit(input logic [1:0] sel, input logic fs_now, input logic fs_prev);
    logic rise;
    logic fall;
    rise = fs_now & ~fs_prev;
    fall = ~fs_now & fs_prev;
    case (sel)
      START_CONT: start_hit = 1'b1;
      START_RISE: start_hit = rise;
      START_FALL: start_hit = fall;
      default:    start_hit = rise | fall;
    endcase
  endfunction

endpackage

// File: rtl/fsr_start_detect.sv
module fsr_start_detect
  import fsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fs_in,
  input  logic [1:0] sel,
  output logic       start_evt
);

  logic fs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fs_q <= 1'b0;
    else        fs_q <= fs_in;
  end

  assign start_evt = start_hit(sel, fs_in, fs_q);

endmodule

// File: rtl/fsr_frame_ctrl.sv
module fsr_frame_ctrl
  import fsr_pkg::*;
#(
  parameter int DLY_W  = 8,
  parameter int LEN_W  = 5,
  parameter int SLEN_W = 5,
  parameter int WCNT_W = 4,
  localparam int IDX_W = (LEN_W > SLEN_W) ? LEN_W : SLEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_cmd,
  input  logic              dis_cmd,
  input  logic              start_evt,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic [SLEN_W-1:0] cfg_sync_len,
  input  logic [LEN_W-1:0]  cfg_data_len,
  input  logic [WCNT_W-1:0] cfg_words,
  output logic              enabled,
  output logic              sample_en,
  output logic              in_sync,
  output logic [IDX_W-1:0]  bit_idx,
  output logic              word_done,
  output logic              sync_done
);

  fsr_state_e        state;
  logic [DLY_W-1:0]  dly_cnt;
  logic [WCNT_W-1:0] word_idx;
  logic [IDX_W-1:0]  sync_last;
  logic [IDX_W-1:0]  data_last;
  logic              field_last;
  fsr_state_e        first_field;

  assign sync_last   = IDX_W'(cfg_sync_len) - 1'b1;
  assign data_last   = IDX_W'(cfg_data_len);
  assign first_field = (cfg_sync_len != '0) ? ST_SYNC : ST_DATA;

  assign enabled    = (state != ST_OFF);
  assign in_sync    = (state == ST_SYNC);
  assign sample_en  = ((state == ST_SYNC) || (state == ST_DATA)) && !dis_cmd;
  assign field_last = in_sync ? (bit_idx == sync_last) : (bit_idx == data_last);
  assign word_done  = sample_en && (state == ST_DATA) && field_last;
  assign sync_done  = sample_en && (state == ST_SYNC) && field_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_OFF;
      dly_cnt  <= '0;
      word_idx <= '0;
      bit_idx  <= '0;
    end else if (dis_cmd) begin
      state   <= ST_OFF;
      bit_idx <= '0;
    end else begin
      case (state)
        ST_OFF: if (en_cmd) state <= ST_WAIT;
        ST_WAIT: begin
          if (start_evt) begin
            if (cfg_delay != '0) begin
              state   <= ST_DELAY;
              dly_cnt <= cfg_delay;
            end else begin
              state    <= first_field;
              bit_idx  <= '0;
              word_idx <= '0;
            end
          end
        end
        ST_DELAY: begin
          if (dly_cnt == DLY_W'(1)) begin
            state    <= first_field;
            bit_idx  <= '0;
            word_idx <= '0;
          end else begin
            dly_cnt <= dly_cnt - 1'b1;
          end
        end
        ST_SYNC: begin
          if (field_last) begin
            state    <= ST_DATA;
            bit_idx  <= '0;
            word_idx <= '0;
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end
        ST_DATA: begin
          if (field_last) begin
            bit_idx <= '0;
            if (word_idx == cfg_words) state <= ST_WAIT;
            else                       word_idx <= word_idx + 1'b1;
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end
        default: state <= ST_OFF;
      endcase
    end
  end

endmodule

// File: rtl/fsr_shifter.sv
module fsr_shifter #(
  parameter int DW    = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic             bit_in,
  input  logic             msb_first,
  input  logic [IDX_W-1:0] bit_idx,
  output logic [DW-1:0]    word_next
);

  logic [DW-1:0] acc;

  // Put one received bit into a partly built word
  function automatic logic [DW-1:0] place_bit(input logic [DW-1:0] base, input logic b,
                                              input logic [IDX_W-1:0] idx, input logic msb);
    logic [DW-1:0] tmp;
    if (msb) begin
      tmp = {base[DW-2:0], b};
    end else begin
      tmp      = base;
      tmp[idx] = b;
    end
    return tmp;
  endfunction

  assign word_next = place_bit((bit_idx == '0) ? '0 : acc, bit_in, bit_idx, msb_first);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         acc <= '0;
    else if (sample_en) acc <= word_next;
  end

endmodule

// File: rtl/fsr_hold_regs.sv
module fsr_hold_regs
  import fsr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_done,
  input  logic          sync_done,
  input  logic [DW-1:0] word_val,
  input  logic          enabled,
  input  logic          rd_en,
  input  logic [1:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rdy,
  output logic          ovr
);

  logic [DW-1:0] hold_q;
  logic [DW-1:0] sync_q;
  logic          rd_hold_hit;
  logic          rd_stat_hit;

  assign rd_hold_hit = rd_en && (rd_addr == ADDR_HOLD);
  assign rd_stat_hit = rd_en && (rd_addr == ADDR_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      sync_q <= '0;
      rdy    <= 1'b0;
      ovr    <= 1'b0;
    end else begin
      if (word_done) hold_q <= word_val;
      if (sync_done) sync_q <= word_val;
      if (word_done)        rdy <= 1'b1;
      else if (rd_hold_hit) rdy <= 1'b0;
      if (word_done && rdy && !rd_hold_hit) ovr <= 1'b1;
      else if (rd_stat_hit)                 ovr <= 1'b0;
    end
  end

  always_comb begin
    case (rd_addr)
      ADDR_HOLD: rd_data = hold_q;
      ADDR_STAT: rd_data = {{(DW-3){1'b0}}, ovr, rdy, enabled};
      ADDR_SYNC: rd_data = sync_q;
      default:   rd_data = '0;
    endcase
  end

endmodule

// File: rtl/fsr_receiver.sv
module fsr_receiver
  import fsr_pkg::*;
#(
  parameter int DW     = 32,
  parameter int DLY_W  = 8,
  parameter int SYNC_W = 16,
  parameter int WCNT_W = 4,
  localparam int LEN_W  = $clog2(DW),
  localparam int SLEN_W = $clog2(SYNC_W + 1),
  localparam int IDX_W  = (LEN_W > SLEN_W) ? LEN_W : SLEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_cmd,
  input  logic              dis_cmd,
  input  logic              rx_data,
  input  logic              rx_fs,
  input  logic [1:0]        cfg_start_sel,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic [SLEN_W-1:0] cfg_sync_len,
  input  logic [LEN_W-1:0]  cfg_data_len,
  input  logic              cfg_msb_first,
  input  logic [WCNT_W-1:0] cfg_words,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              rx_rdy,
  output logic              rx_ovr
);

  logic             start_evt;
  logic             enabled;
  logic             sample_en;
  logic             in_sync;
  logic [IDX_W-1:0] bit_idx;
  logic             word_done;
  logic             sync_done;
  logic [DW-1:0]    word_next;

  fsr_start_detect u_start (
    .clk       (clk),
    .rst_n     (rst_n),
    .fs_in     (rx_fs),
    .sel       (cfg_start_sel),
    .start_evt (start_evt)
  );

  fsr_frame_ctrl #(
    .DLY_W  (DLY_W),
    .LEN_W  (LEN_W),
    .SLEN_W (SLEN_W),
    .WCNT_W (WCNT_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_cmd       (en_cmd),
    .dis_cmd      (dis_cmd),
    .start_evt    (start_evt),
    .cfg_delay    (cfg_delay),
    .cfg_sync_len (cfg_sync_len),
    .cfg_data_len (cfg_data_len),
    .cfg_words    (cfg_words),
    .enabled      (enabled),
    .sample_en    (sample_en),
    .in_sync      (in_sync),
    .bit_idx      (bit_idx),
    .word_done    (word_done),
    .sync_done    (sync_done)
  );

  fsr_shifter #(
    .DW    (DW),
    .IDX_W (IDX_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .bit_in    (rx_data),
    .msb_first (cfg_msb_first),
    .bit_idx   (bit_idx),
    .word_next (word_next)
  );

  fsr_hold_regs #(
    .DW (DW)
  ) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_done (word_done),
    .sync_done (sync_done),
    .word_val  (word_next),
    .enabled   (enabled),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .rdy       (rx_rdy),
    .ovr       (rx_ovr)
  );

endmodule

// File: rtl/fsr_receiver_chk.sv
module fsr_receiver_chk #(
  parameter int LEN_W = 5,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dis_cmd,
  input logic             rd_en,
  input logic [1:0]       rd_addr,
  input logic [LEN_W-1:0] cfg_data_len,
  input logic             rx_rdy,
  input logic             rx_ovr,
  input logic             enabled,
  input logic             sample_en,
  input logic             in_sync,
  input logic [IDX_W-1:0] bit_idx,
  input logic             word_done,
  input logic             sync_done
);

  assert_disable_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dis_cmd |=> (!enabled && !sample_en));

  assert_rdy_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_rdy) |-> $past(word_done));

  assert_ovr_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> $past(word_done && rx_rdy));

  assert_len_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !in_sync) |-> (IDX_W'(cfg_data_len) >= bit_idx));

  assert_sync_no_rdy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_done && !rx_rdy) |=> !rx_rdy);

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 2'd0 && !word_done) |=> !rx_rdy);

endmodule

bind fsr_receiver fsr_receiver_chk #(
  .LEN_W (LEN_W),
  .IDX_W (IDX_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dis_cmd      (dis_cmd),
  .rd_en        (rd_en),
  .rd_addr      (rd_addr),
  .cfg_data_len (cfg_data_len),
  .rx_rdy       (rx_rdy),
  .rx_ovr       (rx_ovr),
  .enabled      (enabled),
  .sample_en    (sample_en),
  .in_sync      (in_sync),
  .bit_idx      (bit_idx),
  .word_done    (word_done),
  .sync_done    (sync_done)
);

// File: tb/fsr_receiver_tb.sv
module fsr_receiver_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_cmd = 1'b0, dis_cmd = 1'b0, rx_data = 1'b0, rx_fs = 1'b0;
  logic [1:0]  cfg_start_sel = 2'd0;
  logic [7:0]  cfg_delay = 8'd0;
  logic [4:0]  cfg_sync_len = 5'd0, cfg_data_len = 5'd7;
  logic        cfg_msb_first = 1'b1;
  logic [3:0]  cfg_words = 4'd0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = 2'd0;
  logic [31:0] rd_data;
  logic        rx_rdy, rx_ovr;

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  fsr_receiver u_dut (.*);

  // Behavioural reference: modes 0 off, 1 waiting, 2 delay, 3 sync, 4 data
  int m_mode, m_cnt, m_idx, m_word;
  logic [31:0] m_acc, m_hold, m_sync;
  bit m_rdy, m_ovr, m_fsq;
  bit st, wd, rdh, sth;

  function automatic logic [31:0] put(input logic [31:0] a, input bit b, input int idx, input bit msb);
    if (msb) return (a << 1) | 32'(b);
    return a | (32'(b) << idx);
  endfunction

  task automatic m_enter();
    m_mode = (cfg_sync_len != 0) ? 3 : 4;
    m_idx = 0;
    m_word = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_idx = 0; m_word = 0;
      m_acc = 0; m_hold = 0; m_sync = 0; m_rdy = 0; m_ovr = 0; m_fsq = 0;
    end else begin
      case (cfg_start_sel)
        2'd0: st = 1;
        2'd1: st = rx_fs && !m_fsq;
        2'd2: st = !rx_fs && m_fsq;
        default: st = rx_fs != m_fsq;
      endcase
      wd = 0;
      rdh = rd_en && rd_addr == 2'd0;
      sth = rd_en && rd_addr == 2'd1;
      if (dis_cmd) m_mode = 0;
      else case (m_mode)
        0: if (en_cmd) m_mode = 1;
        1: if (st) begin
             if (cfg_delay != 0) begin m_mode = 2; m_cnt = cfg_delay; end
             else m_enter();
           end
        2: if (m_cnt == 1) m_enter(); else m_cnt--;
        3: begin
             m_acc = put(m_idx == 0 ? 32'd0 : m_acc, rx_data, m_idx, cfg_msb_first);
             if (m_idx == cfg_sync_len - 1) begin
               m_sync = m_acc; m_mode = 4; m_idx = 0; m_word = 0;
             end else m_idx++;
           end
        4: begin
             m_acc = put(m_idx == 0 ? 32'd0 : m_acc, rx_data, m_idx, cfg_msb_first);
             if (m_idx == cfg_data_len) begin
               wd = 1; m_hold = m_acc; m_idx = 0;
               if (m_word == cfg_words) m_mode = 1; else m_word++;
             end else m_idx++;
           end
        default: m_mode = 0;
      endcase
      m_ovr = (wd && m_rdy && !rdh) ? 1 : (sth ? 0 : m_ovr);
      m_rdy = wd ? 1 : (rdh ? 0 : m_rdy);
      m_fsq = rx_fs;
    end
  end

  task automatic compare(input string tag);
    logic [31:0] exp;
    case (rd_addr)
      2'd0: exp = m_hold;
      2'd1: exp = {29'd0, m_ovr, m_rdy, m_mode != 0};
      2'd2: exp = m_sync;
      default: exp = 0;
    endcase
    vectors++;
    if (rd_data !== exp || rx_rdy !== m_rdy || rx_ovr !== m_ovr) begin
      miscompares++;
      $display("FAIL %s addr=%0d: rd_data=%h rdy=%b ovr=%b, expected %h %b %b",
               tag, rd_addr, rd_data, rx_rdy, rx_ovr, exp, m_rdy, m_ovr);
    end
  endtask

  task automatic cmd(input bit en, input bit dis, input string tag);
    @(negedge clk); compare(tag);
    en_cmd = en; dis_cmd = dis; rd_en = 0;
    @(negedge clk); compare(tag);
    en_cmd = 0; dis_cmd = 0;
  endtask

  // Random data and reads; fs toggles every fs_per cycles (0 = held)
  task automatic run(input int n, input int fs_per, input int rd_rate, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); compare(tag);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rx_data = lfsr[0];
      if (fs_per != 0 && (i % fs_per) == 0) rx_fs = ~rx_fs;
      rd_en = (int'(lfsr[7:4]) < rd_rate);
      rd_addr = lfsr[9:8];
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_addr = 2'd1;
    compare("R10 reset status");
    // R1: disabled, fs toggles and data moves, nothing captured
    cfg_start_sel = 2'd3;
    run(200, 3, 6, "R1 disabled");
    // R2 R3 R4 R7: rising start, delay 5, 8-bit MSB first, two words
    cfg_start_sel = 2'd1; cfg_delay = 8'd5; cfg_data_len = 5'd7; cfg_msb_first = 1; cfg_words = 4'd1;
    cmd(1, 0, "R1 enable");
    run(1500, 37, 3, "R2 R3 R4 R7");
    // R6 R7: falling start, 32-bit LSB first
    cmd(0, 1, "R1 disable");
    cfg_start_sel = 2'd2; cfg_delay = 8'd0; cfg_data_len = 5'd31; cfg_msb_first = 0; cfg_words = 4'd0;
    cmd(1, 0, "R1 enable");
    run(1500, 45, 2, "R6 R7");
    // R5 R6: continuous start, 1-bit words, no reads -> overrun
    cmd(0, 1, "R1 disable");
    cfg_start_sel = 2'd0; cfg_data_len = 5'd0; cfg_msb_first = 1; cfg_words = 4'd15;
    cmd(1, 0, "R1 enable");
    run(300, 0, 0, "R5 R6 overrun");
    run(600, 0, 4, "R5 R10 reads");
    // R8 R9: any edge, 5-bit sync, three 12-bit words
    cmd(0, 1, "R1 disable");
    cfg_start_sel = 2'd3; cfg_delay = 8'd2; cfg_sync_len = 5'd5; cfg_data_len = 5'd11; cfg_words = 4'd2;
    cmd(1, 0, "R1 enable");
    run(2000, 53, 3, "R8 R9");
    // R1: disable mid-frame, edges keep coming, flags hold
    cmd(0, 1, "R1 mid-frame disable");
    run(300, 4, 0, "R1 ignored start");
    cmd(1, 1, "R1 disable wins");
    run(200, 5, 8, "R1 R10 after");
    // R7 R9: LSB-first sync field of 16 bits
    cfg_msb_first = 0; cfg_sync_len = 5'd16; cfg_delay = 8'd0; cfg_words = 4'd0;
    cmd(1, 0, "R1 enable");
    run(1200, 60, 5, "R7 R9 lsb sync");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule